// File: doc/BRIEF.md
# Pointer-Selected Register File

This block holds six general registers, named Q, R, S, T, U and V, each 16 bits wide. Commands never name their operands directly. Two 3-bit selector registers, the A-pointer and the B-pointer, choose which general registers act as operand A and operand B. Commands re-aim those pointers, and register V also serves as a fixed side operand. A command is presented on a valid-qualified command bus and takes effect at the next rising clock edge. Each command carries a 5-bit operation code, a 3-bit register field and an 8-bit immediate.

The commands cover several groups: loading a zero-extended constant into a named or pointed-at register, re-aiming either pointer, exchanging the pointers, stepping the pointed-at registers up or down, copying and exchanging between the two operands, bitwise logic into A, and moving values between A and V. The current A, B and V values and both pointers are driven on outputs for neighbouring datapath units. A write-back input lets such a unit return a result into the A-pointed register in any cycle with no command.

Register indices are Q=0, R=1, S=2, T=3, U=4, V=5.

Top module: `ptr_regfile`

## Requirements
- R1: After reset every register reads zero, the A-pointer is 0 (Q) and the B-pointer is 1 (R).
- R2: Operation 1 writes the zero-extended immediate into the register whose index is in the register field. Field values 6 and 7 change nothing.
- R3: Operation 2 writes the zero-extended immediate into the A-pointed register. Operation 3 writes it into the B-pointed register.
- R4: Operation 4 sets the A-pointer, and operation 5 sets the B-pointer, to the register field. A field of 6 or 7 leaves the pointer unchanged. No register content changes.
- R5: Operation 12 exchanges the A-pointer and B-pointer values and changes no register content.
- R6: Operations 6 and 7 add one to the A-pointed and B-pointed register respectively. Operations 8 and 9 subtract one from them. All arithmetic wraps modulo 2^16.
- R7: Operation 10 increments, and operation 11 decrements, both pointed-at registers in one cycle. When both pointers name the same register, that register changes by exactly one.
- R8: Operation 13 copies A into the B-pointed register. Operation 14 copies B into the A-pointed register. Operation 15 exchanges the contents of the two pointed-at registers.
- R9: Operation 16 inverts A in place, operation 17 inverts B in place, and operation 18 writes the inverse of B into A.
- R10: Operations 19 to 24 write into the A-pointed register A OR B, A AND B, A XOR B, NOR, NAND and XNOR respectively. Only that register changes.
- R11: Operation 25 copies A into V. Operation 26 copies V into the A-pointed register.
- R12: Operation 0 and operations 27 to 31 change no register and no pointer.
- R13: When the write-back valid is high and no command is valid, the write-back data goes into the A-pointed register. When a command is valid in the same cycle, the write-back is ignored.
- R14: The A, B and V outputs follow the stored values combinationally. A command's effect appears on them after the clock edge that accepts it, and not before.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 5 | Operation code |
| cmd_reg | input | 3 | Register index field |
| cmd_imm | input | 8 | Immediate constant |
| wb_valid | input | 1 | Write-back request |
| wb_data | input | 16 | Write-back value for the A-pointed register |
| a_sel | output | 3 | Current A-pointer |
| b_sel | output | 3 | Current B-pointer |
| a_val | output | 16 | Value of the A-pointed register |
| b_val | output | 16 | Value of the B-pointed register |
| v_val | output | 16 | Value of register V |

## Verification
A corrupted pointer shows up at once on a_sel or b_sel, and on the operand outputs, one cycle after the command that caused it. A wrong register value stays hidden until some pointer reaches that register. For that reason, after each command the bench walks the A-pointer across all six registers, so any stray write shows within six cycles. The sweep covers every operation code against every pairing of the two pointers, including the aliased case where both name one register.

// File: rtl/ptrf_pkg.sv
package ptrf_pkg;
  localparam int unsigned NREG  = 6;
  localparam int unsigned SELW  = 3;
  localparam int unsigned NSLOT = 1 << SELW;
  localparam logic [SELW-1:0] IDX_Q = 3'd0;
  localparam logic [SELW-1:0] IDX_R = 3'd1;
  localparam logic [SELW-1:0] IDX_V = 3'd5;

  typedef enum logic [4:0] {
    OP_NOP     = 5'd0,
    OP_LDC_N   = 5'd1,
    OP_LDC_A   = 5'd2,
    OP_LDC_B   = 5'd3,
    OP_SEL_A   = 5'd4,
    OP_SEL_B   = 5'd5,
    OP_INC_A   = 5'd6,
    OP_INC_B   = 5'd7,
    OP_DEC_A   = 5'd8,
    OP_DEC_B   = 5'd9,
    OP_INC_AB  = 5'd10,
    OP_DEC_AB  = 5'd11,
    OP_SWP_SEL = 5'd12,
    OP_CPY_AB  = 5'd13,
    OP_CPY_BA  = 5'd14,
    OP_XCHG    = 5'd15,
    OP_NOT_A   = 5'd16,
    OP_NOT_B   = 5'd17,
    OP_NOT_BA  = 5'd18,
    OP_OR      = 5'd19,
    OP_AND     = 5'd20,
    OP_XOR     = 5'd21,
    OP_NOR     = 5'd22,
    OP_NAND    = 5'd23,
    OP_XNOR    = 5'd24,
    OP_PUT_V   = 5'd25,
    OP_TAKE_V  = 5'd26
  } ptrf_op_e;
endpackage

// File: rtl/ptrf_selectors.sv
module ptrf_selectors
  import ptrf_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cmd_valid,
  input  logic [4:0]      cmd_op,
  input  logic [SELW-1:0] cmd_reg,
  output logic [SELW-1:0] a_sel,
  output logic [SELW-1:0] b_sel
);
  logic reg_ok;
  logic swap_ev;
  assign reg_ok  = (cmd_reg < SELW'(NREG));
  assign swap_ev = cmd_valid && (cmd_op == OP_SWP_SEL);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      a_sel <= IDX_Q;
      b_sel <= IDX_R;
    end else if (cmd_valid) begin
      case (cmd_op)
        OP_SEL_A:   if (reg_ok) a_sel <= cmd_reg;
        OP_SEL_B:   if (reg_ok) b_sel <= cmd_reg;
        OP_SWP_SEL: begin
          a_sel <= b_sel;
          b_sel <= a_sel;
        end
        default: ;
      endcase
    end
  end

  // R4
  sel_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (a_sel < SELW'(NREG)) && (b_sel < SELW'(NREG)));

  // R5
  sel_swap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    swap_ev |=> (a_sel == $past(b_sel)) && (b_sel == $past(a_sel)));
endmodule

// File: rtl/ptrf_alu.sv
module ptrf_alu
  import ptrf_pkg::*;
#(
  parameter int unsigned DW = 16,
  parameter int unsigned IW = 8
)(
  input  logic            cmd_valid,
  input  logic [4:0]      cmd_op,
  input  logic [SELW-1:0] cmd_reg,
  input  logic [IW-1:0]   cmd_imm,
  input  logic            wb_valid,
  input  logic [DW-1:0]   wb_data,
  input  logic [DW-1:0]   a_cur,
  input  logic [DW-1:0]   b_cur,
  input  logic [DW-1:0]   v_cur,
  output logic            a_we,
  output logic [DW-1:0]   a_wd,
  output logic            b_we,
  output logic [DW-1:0]   b_wd,
  output logic            n_we,
  output logic [SELW-1:0] n_idx,
  output logic [DW-1:0]   n_wd
);
  function automatic logic [DW-1:0] zext(input logic [IW-1:0] k);
    return DW'(k);
  endfunction

  function automatic logic [DW-1:0] step(input logic [DW-1:0] x, input logic up);
    return up ? DW'(x + 1'b1) : DW'(x - 1'b1);
  endfunction

  function automatic logic [DW-1:0] bitop(input logic [4:0] op,
                                          input logic [DW-1:0] x,
                                          input logic [DW-1:0] y);
    case (op)
      OP_OR:   return x | y;
      OP_AND:  return x & y;
      OP_XOR:  return x ^ y;
      OP_NOR:  return ~(x | y);
      OP_NAND: return ~(x & y);
      default: return ~(x ^ y);
    endcase
  endfunction

  always_comb begin
    a_we  = 1'b0;
    a_wd  = '0;
    b_we  = 1'b0;
    b_wd  = '0;
    n_we  = 1'b0;
    n_idx = '0;
    n_wd  = '0;
    if (cmd_valid) begin
      case (cmd_op)
        OP_LDC_N: begin
          n_we  = (cmd_reg < SELW'(NREG));
          n_idx = cmd_reg;
          n_wd  = zext(cmd_imm);
        end
        OP_LDC_A:  begin a_we = 1'b1; a_wd = zext(cmd_imm); end
        OP_LDC_B:  begin b_we = 1'b1; b_wd = zext(cmd_imm); end
        OP_INC_A:  begin a_we = 1'b1; a_wd = step(a_cur, 1'b1); end
        OP_INC_B:  begin b_we = 1'b1; b_wd = step(b_cur, 1'b1); end
        OP_DEC_A:  begin a_we = 1'b1; a_wd = step(a_cur, 1'b0); end
        OP_DEC_B:  begin b_we = 1'b1; b_wd = step(b_cur, 1'b0); end
        OP_INC_AB: begin
          a_we = 1'b1; a_wd = step(a_cur, 1'b1);
          b_we = 1'b1; b_wd = step(b_cur, 1'b1);
        end
        OP_DEC_AB: begin
          a_we = 1'b1; a_wd = step(a_cur, 1'b0);
          b_we = 1'b1; b_wd = step(b_cur, 1'b0);
        end
        OP_CPY_AB: begin b_we = 1'b1; b_wd = a_cur; end
        OP_CPY_BA: begin a_we = 1'b1; a_wd = b_cur; end
        OP_XCHG: begin
          a_we = 1'b1; a_wd = b_cur;
          b_we = 1'b1; b_wd = a_cur;
        end
        OP_NOT_A:  begin a_we = 1'b1; a_wd = ~a_cur; end
        OP_NOT_B:  begin b_we = 1'b1; b_wd = ~b_cur; end
        OP_NOT_BA: begin a_we = 1'b1; a_wd = ~b_cur; end
        OP_OR, OP_AND, OP_XOR, OP_NOR, OP_NAND, OP_XNOR: begin
          a_we = 1'b1;
          a_wd = bitop(cmd_op, a_cur, b_cur);
        end
        OP_PUT_V:  begin n_we = 1'b1; n_idx = IDX_V; n_wd = a_cur; end
        OP_TAKE_V: begin a_we = 1'b1; a_wd = v_cur; end
        default: ;
      endcase
    end else if (wb_valid) begin
      a_we = 1'b1;
      a_wd = wb_data;
    end
  end

  // R3
  ldc_zext_chk: assert final (!(cmd_valid && cmd_op == OP_LDC_A) || (a_wd >> IW) == '0);
endmodule

// File: rtl/ptrf_bank.sv
module ptrf_bank
  import ptrf_pkg::*;
#(
  parameter int unsigned DW = 16
)(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [SELW-1:0] a_sel,
  input  logic [SELW-1:0] b_sel,
  input  logic            a_we,
  input  logic [DW-1:0]   a_wd,
  input  logic            b_we,
  input  logic [DW-1:0]   b_wd,
  input  logic            n_we,
  input  logic [SELW-1:0] n_idx,
  input  logic [DW-1:0]   n_wd,
  output logic [DW-1:0]   a_val,
  output logic [DW-1:0]   b_val,
  output logic [DW-1:0]   v_val
);
  logic [NSLOT*DW-1:0] flat;
  logic [NSLOT-1:0]    wr_hit;

  for (genvar i = 0; i < NSLOT; i++) begin : g_slot
    if (i < NREG) begin : g_live
      logic          hit_n, hit_b, hit_a;
      logic [DW-1:0] q;
      assign hit_n = n_we && (n_idx == SELW'(i));
      assign hit_b = b_we && (b_sel == SELW'(i));
      assign hit_a = a_we && (a_sel == SELW'(i));
      assign wr_hit[i] = hit_n | hit_b | hit_a;
      always_ff @(posedge clk) begin
        if (!rst_n)         q <= '0;
        else if (wr_hit[i]) q <= hit_n ? n_wd : (hit_b ? b_wd : a_wd);
      end
      assign flat[i*DW +: DW] = q;
    end else begin : g_hole
      assign wr_hit[i] = 1'b0;
      assign flat[i*DW +: DW] = '0;
    end
  end

  assign a_val = flat[a_sel*DW +: DW];
  assign b_val = flat[b_sel*DW +: DW];
  assign v_val = flat[IDX_V*DW +: DW];

  // R12
  two_writes_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(wr_hit) <= 2);

  // R11
  v_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_hit[IDX_V] |=> v_val == $past(v_val));
endmodule

// File: rtl/ptr_regfile.sv
module ptr_regfile
  import ptrf_pkg::*;
#(
  parameter int unsigned DW = 16,
  parameter int unsigned IW = 8
)(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  input  logic [4:0]    cmd_op,
  input  logic [2:0]    cmd_reg,
  input  logic [IW-1:0] cmd_imm,
  input  logic          wb_valid,
  input  logic [DW-1:0] wb_data,
  output logic [2:0]    a_sel,
  output logic [2:0]    b_sel,
  output logic [DW-1:0] a_val,
  output logic [DW-1:0] b_val,
  output logic [DW-1:0] v_val
);
  logic            a_we, b_we, n_we;
  logic [DW-1:0]   a_wd, b_wd, n_wd;
  logic [SELW-1:0] n_idx;

  ptrf_selectors u_sel (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_reg(cmd_reg), .a_sel(a_sel), .b_sel(b_sel)
  );

  ptrf_alu #(.DW(DW), .IW(IW)) u_alu (
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_reg(cmd_reg), .cmd_imm(cmd_imm),
    .wb_valid(wb_valid), .wb_data(wb_data),
    .a_cur(a_val), .b_cur(b_val), .v_cur(v_val),
    .a_we(a_we), .a_wd(a_wd), .b_we(b_we), .b_wd(b_wd),
    .n_we(n_we), .n_idx(n_idx), .n_wd(n_wd)
  );

  ptrf_bank #(.DW(DW)) u_bank (
    .clk(clk), .rst_n(rst_n), .a_sel(a_sel), .b_sel(b_sel),
    .a_we(a_we), .a_wd(a_wd), .b_we(b_we), .b_wd(b_wd),
    .n_we(n_we), .n_idx(n_idx), .n_wd(n_wd),
    .a_val(a_val), .b_val(b_val), .v_val(v_val)
  );

  logic inc_a_ev, inc_ab_alias_ev, logic_ev, sel_ev, wb_ev;
  assign inc_a_ev        = cmd_valid && (cmd_op == OP_INC_A) && (a_sel != b_sel);
  assign inc_ab_alias_ev = cmd_valid && (cmd_op == OP_INC_AB) && (a_sel == b_sel);
  assign logic_ev        = cmd_valid && (cmd_op >= OP_OR) && (cmd_op <= OP_XNOR)
                           && (a_sel != b_sel);
  assign sel_ev          = cmd_valid && ((cmd_op == OP_SEL_A) || (cmd_op == OP_SEL_B));
  assign wb_ev           = wb_valid && !cmd_valid;

  // R6
  inc_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inc_a_ev |=> a_val == DW'($past(a_val) + 1'b1));

  // R7
  inc_alias_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inc_ab_alias_ev |=> a_val == DW'($past(a_val) + 1'b1));

  // R10
  logic_keeps_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
    logic_ev |=> b_val == $past(b_val));

  // R4
  sel_keeps_v_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sel_ev |=> v_val == $past(v_val));

  // R13
  wb_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_ev |=> a_val == $past(wb_data));
endmodule

// File: tb/tb_ptr_regfile.sv
module tb_ptr_regfile;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [4:0]  cmd_op = '0;
  logic [2:0]  cmd_reg = '0;
  logic [7:0]  cmd_imm = '0;
  logic        wb_valid = 1'b0;
  logic [15:0] wb_data = '0;
  logic [2:0]  a_sel, b_sel;
  logic [15:0] a_val, b_val, v_val;

  ptr_regfile dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_reg(cmd_reg), .cmd_imm(cmd_imm), .wb_valid(wb_valid), .wb_data(wb_data),
    .a_sel(a_sel), .b_sel(b_sel), .a_val(a_val), .b_val(b_val), .v_val(v_val)
  );

  always #5 clk = ~clk;

  int checks = 0;
  int failures = 0;
  logic [15:0] m_reg [6];
  int m_a = 0;
  int m_b = 1;
  logic [31:0] seed = 32'h1234_5678;

  function automatic string tag_of(input int op);
    if (op == 1) return "R2";
    if (op == 2 || op == 3) return "R3";
    if (op == 4 || op == 5) return "R4";
    if (op == 12) return "R5";
    if (op >= 6 && op <= 9) return "R6";
    if (op == 10 || op == 11) return "R7";
    if (op >= 13 && op <= 15) return "R8";
    if (op >= 16 && op <= 18) return "R9";
    if (op >= 19 && op <= 24) return "R10";
    if (op == 25 || op == 26) return "R11";
    return "R12";
  endfunction

  function automatic logic [31:0] rnd();
    seed = seed * 32'd1103515245 + 32'd12345;
    return seed;
  endfunction

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic cmp(input string tag);
    chk(tag, "a_sel", int'(a_sel), m_a);
    chk(tag, "b_sel", int'(b_sel), m_b);
    chk(tag, "a_val", int'(a_val), int'(m_reg[m_a]));
    chk(tag, "b_val", int'(b_val), int'(m_reg[m_b]));
    chk(tag, "v_val", int'(v_val), int'(m_reg[5]));
  endtask

  task automatic model(input int op, input int r, input logic [7:0] k);
    logic [15:0] av, bv, vv, kz;
    int t;
    av = m_reg[m_a]; bv = m_reg[m_b]; vv = m_reg[5]; kz = {8'h00, k};
    case (op)
      1: if (r < 6) m_reg[r] = kz;
      2: m_reg[m_a] = kz;
      3: m_reg[m_b] = kz;
      4: if (r < 6) m_a = r;
      5: if (r < 6) m_b = r;
      6: m_reg[m_a] = av + 16'd1;
      7: m_reg[m_b] = bv + 16'd1;
      8: m_reg[m_a] = av - 16'd1;
      9: m_reg[m_b] = bv - 16'd1;
      10: begin m_reg[m_a] = av + 16'd1; m_reg[m_b] = bv + 16'd1; end
      11: begin m_reg[m_a] = av - 16'd1; m_reg[m_b] = bv - 16'd1; end
      12: begin t = m_a; m_a = m_b; m_b = t; end
      13: m_reg[m_b] = av;
      14: m_reg[m_a] = bv;
      15: begin m_reg[m_a] = bv; m_reg[m_b] = av; end
      16: m_reg[m_a] = ~av;
      17: m_reg[m_b] = ~bv;
      18: m_reg[m_a] = ~bv;
      19: m_reg[m_a] = av | bv;
      20: m_reg[m_a] = av & bv;
      21: m_reg[m_a] = av ^ bv;
      22: m_reg[m_a] = ~(av | bv);
      23: m_reg[m_a] = ~(av & bv);
      24: m_reg[m_a] = ~(av ^ bv);
      25: m_reg[5] = av;
      26: m_reg[m_a] = vv;
      default: ;
    endcase
  endtask

  // called at a falling edge; returns at the next falling edge
  task automatic run(input int op, input int r, input logic [7:0] k, input string tag);
    cmd_valid = 1'b1; cmd_op = 5'(op); cmd_reg = 3'(r); cmd_imm = k;
    @(posedge clk); #2;
    model(op, r, k);
    cmp(tag);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic walk(input string tag);
    for (int i = 0; i < 6; i++) run(4, i, 8'h00, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int i = 0; i < 6; i++) m_reg[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #2;
    // R1 reset state
    cmp("R1");
    @(negedge clk);
    walk("R1");
    run(4, 0, 0, "R1");
    run(5, 1, 0, "R1");

    // R6 wrap at both ends
    run(2, 0, 8'h00, "R3");
    run(8, 0, 0, "R6");
    chk("R6", "dec wrap", int'(a_val), 16'hFFFF);
    run(6, 0, 0, "R6");
    chk("R6", "inc wrap", int'(a_val), 0);

    // R2 field 6 and 7 ignored, R4 same
    run(1, 6, 8'hAA, "R2");
    run(1, 7, 8'hBB, "R2");
    run(4, 7, 0, "R4");
    run(5, 6, 0, "R4");
    walk("R2");

    // R14 output timing
    run(4, 2, 0, "R14");
    cmd_valid = 1'b1; cmd_op = 5'd2; cmd_imm = 8'h5A;
    #1;
    chk("R14", "a_val before edge", int'(a_val), int'(m_reg[2]));
    @(posedge clk); #2;
    model(2, 0, 8'h5A);
    chk("R14", "a_val after edge", int'(a_val), 16'h005A);
    @(negedge clk); cmd_valid = 1'b0;

    // R13 write-back alone and with a command
    wb_valid = 1'b1; wb_data = 16'hC3E1;
    @(posedge clk); #2;
    m_reg[m_a] = 16'hC3E1;
    cmp("R13");
    @(negedge clk);
    wb_data = 16'h1111;
    run(0, 0, 0, "R13");
    wb_valid = 1'b0;
    walk("R13");

    // exhaustive: every op against every pointer pair
    for (int op = 0; op < 32; op++) begin
      for (int pa = 0; pa < 6; pa++) begin
        for (int pb = 0; pb < 6; pb++) begin
          logic [31:0] x;
          for (int i = 0; i < 6; i++) begin
            x = rnd();
            run(1, i, x[15:8], "R2");
            if (x[20]) begin
              run(4, i, 0, "R4");
              run(16, 0, 0, "R9");
            end
          end
          run(4, pa, 0, "R4");
          run(5, pb, 0, "R4");
          x = rnd();
          run(op, int'(x[18:16]), x[27:20], tag_of(op));
          walk(tag_of(op));
        end
      end
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule